// File: doc/BRIEF.md
# Timestamped capture chunk decoder

This block turns the byte stream read out of a logic-capture memory into a flat stream of 16-bit samples. The memory holds data in chunks of 64 clusters. Each cluster is eight little-endian 16-bit words: a timestamp word, then seven event words. Time runs in event units. When the inputs sat idle, the capture logic stored nothing, so the timestamp jumps forward. The decoder rebuilds those idle stretches by repeating the last sample it sent.

At the two faster sampling modes, one event word carries several time-consecutive samples of fewer channels, packed channel-major. The decoder splits such a word into separate samples. For channel `l` of sub-sample `k`, with `S` samples per event, the bit is at position `l*S + k`. A nonzero limit input marks the last valid timestamp of a partly filled chunk. A capture-start pulse re-aligns the decoder to a chunk boundary before a new capture is read out. Bytes enter on a valid/ready stream and samples leave on a valid/ready stream. Backpressure on the output stalls both unpacking and gap filling.

Top module: `cdec_chunk_decoder`

## Requirements
- R1: Input bytes pair into 16-bit words, low byte first. Word 0 of each 8-word cluster is the timestamp and words 1..7 are events. 64 clusters form one chunk, and decoding state carries across consecutive chunks.
- R2: With `mode` = 2'b00 (and with 2'b11, which behaves the same), each event word yields one sample equal to the word.
- R3: With `mode` = 2'b01, each event yields two samples, k = 0 then 1. Sample bit `l` (0..7) equals event bit `2*l+k`, and sample bits 15..8 are zero.
- R4: With `mode` = 2'b10, each event yields four samples, k = 0..3. Sample bit `l` (0..3) equals event bit `4*l+k`, and sample bits 15..4 are zero.
- R5: Let `d` be the cluster timestamp minus the reference timestamp, taken modulo 2^16, and let `S` be the samples per event. When `d > 7`, the previous output sample is emitted `(d-7)*S` times before the cluster's own samples. The cluster's timestamp then becomes the reference.
- R6: A one-cycle `cap_start` pulse re-aligns decoding to a chunk start and clears the last sample to zero. The first decoded cluster after it uses its own timestamp minus one as the reference, so no padding precedes it.
- R7: When `limit` is nonzero and a cluster timestamp is greater than `limit` (unsigned), that cluster and the rest of its chunk are consumed without any output. They leave the reference and the last sample unchanged. The next chunk decodes normally. A `limit` of zero disables the check.
- R8: While `out_valid` is high and `out_ready` is low, `out_sample` holds its value. Every expected sample appears exactly once and in order, whatever the stalls on either side.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_start | input | 1 | One-cycle pulse that begins a new capture readout |
| mode | input | 2 | Samples per event: 00 one, 01 two, 10 four, 11 one |
| limit | input | 16 | Last valid timestamp of a partial chunk; 0 disables |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts the sample |
| out_sample | output | 16 | Decoded sample, one bit per channel |

## Verification
On every cycle, the assertions check several invariants. A stalled sample stays stable. The lanes that a two- or four-sample mode does not use stay zero. Timestamp words are consumed only where a cluster boundary is expected. A pending pad count is never zero. A skipped chunk tail never starts a new output. A capture start returns the sequencer to the cluster-start state.

Some behaviour only the bench scenarios can show. These are the exact repeat counts across timestamp wrap and across chunk boundaries, and the bit order of the de-interleaving. They also include the reference left untouched by a limited chunk and the lossless ordering under random stalls. The bench compares these against a sample list built from the cluster contents.

// File: rtl/cdec_pkg.sv
`timescale 1ns/1ps
package cdec_pkg;

  typedef enum logic [2:0] {
    ST_TS,    // waiting for a cluster timestamp
    ST_PAD,   // repeating the previous sample across an idle gap
    ST_EVT,   // waiting for an event word
    ST_SUB,   // emitting the sub-samples of the held event
    ST_SKIP   // discarding the rest of a chunk past the limit
  } seq_state_t;

  // Largest log2 of samples per event supported by the mode encoding.
  localparam int MAX_SPE_LOG2 = 2;

  function automatic logic [1:0] spe_log2(input logic [1:0] mode);
    case (mode)
      2'b01:   return 2'd1;
      2'b10:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/cdec_word_collect.sv
`timescale 1ns/1ps
module cdec_word_collect #(
  parameter int BYTE_W   = 8,
  parameter int EVENTS   = 7,
  parameter int CLUSTERS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_data,
  output logic                in_ready,
  output logic                word_valid,
  output logic [2*BYTE_W-1:0] word_data,
  output logic                word_is_ts,
  output logic                word_cluster_end,
  output logic                word_chunk_end,
  input  logic                word_take
);
  localparam int WPOS_W = $clog2(EVENTS + 1);
  localparam int CPOS_W = $clog2(CLUSTERS);

  logic [BYTE_W-1:0] lo_q;
  logic              have_lo;
  logic [WPOS_W-1:0] wpos;
  logic [CPOS_W-1:0] cpos;
  logic              at_cl_end;
  logic              at_ch_end;

  assign at_cl_end = (wpos == WPOS_W'(EVENTS));
  assign at_ch_end = at_cl_end && (cpos == CPOS_W'(CLUSTERS - 1));
  assign in_ready  = !word_valid;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      lo_q             <= '0;
      have_lo          <= 1'b0;
      wpos             <= '0;
      cpos             <= '0;
      word_valid       <= 1'b0;
      word_data        <= '0;
      word_is_ts       <= 1'b0;
      word_cluster_end <= 1'b0;
      word_chunk_end   <= 1'b0;
    end else begin
      if (word_take) word_valid <= 1'b0;
      if (in_valid && in_ready) begin
        if (!have_lo) begin
          lo_q    <= in_data;
          have_lo <= 1'b1;
        end else begin
          word_data        <= {in_data, lo_q};
          have_lo          <= 1'b0;
          word_valid       <= 1'b1;
          word_is_ts       <= (wpos == '0);
          word_cluster_end <= at_cl_end;
          word_chunk_end   <= at_ch_end;
          if (at_cl_end) begin
            wpos <= '0;
            cpos <= at_ch_end ? '0 : cpos + 1'b1;
          end else begin
            wpos <= wpos + 1'b1;
          end
        end
      end
    end
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst || restart)
    word_valid && !word_take |=> word_valid && $stable(word_data)); // R1

endmodule

// File: rtl/cdec_unpack.sv
`timescale 1ns/1ps
module cdec_unpack #(
  parameter int CH_W     = 16,
  parameter int LOG2_MAX = 2
) (
  input  logic [CH_W-1:0]     word,
  input  logic [LOG2_MAX-1:0] sub,
  input  logic [1:0]          spe_lg,
  output logic [CH_W-1:0]     sample
);
  localparam int NVAR  = LOG2_MAX + 1;
  localparam int IDX_W = $clog2(CH_W);

  logic [CH_W-1:0] lane [NVAR];

  for (genvar v = 0; v < NVAR; v++) begin : g_var
    localparam int S = 1 << v;
    localparam int N = CH_W / S;
    logic [LOG2_MAX-1:0] kk;
    logic [CH_W-1:0]     vec;
    assign kk = sub & LOG2_MAX'(S - 1);
    for (genvar l = 0; l < CH_W; l++) begin : g_ch
      if (l < N) begin : g_used
        assign vec[l] = word[IDX_W'(l * S) + IDX_W'(kk)];
      end else begin : g_zero
        assign vec[l] = 1'b0;
      end
    end
    assign lane[v] = vec;
  end

  always_comb begin
    sample = lane[0];
    for (int v = 1; v < NVAR; v++)
      if (spe_lg == 2'(v)) sample = lane[v];
  end

endmodule

// File: rtl/cdec_gap_calc.sv
`timescale 1ns/1ps
module cdec_gap_calc #(
  parameter int TS_W     = 16,
  parameter int EVENTS   = 7,
  parameter int LOG2_MAX = 2
) (
  input  logic [TS_W-1:0]          ts,
  input  logic [TS_W-1:0]          base_ts,
  input  logic [TS_W-1:0]          limit,
  input  logic                     first,
  input  logic [1:0]               spe_lg,
  output logic [TS_W+LOG2_MAX-1:0] pad,
  output logic                     beyond
);
  localparam int PAD_W = TS_W + LOG2_MAX;

  logic [TS_W-1:0] diff;
  logic [TS_W-1:0] excess;

  assign diff   = first ? TS_W'(1) : ts - base_ts;
  assign excess = diff - TS_W'(EVENTS);
  assign pad    = (diff > TS_W'(EVENTS)) ? (PAD_W'(excess) << spe_lg) : '0;
  assign beyond = (limit != '0) && (ts > limit);

endmodule

// File: rtl/cdec_chunk_decoder.sv
`timescale 1ns/1ps
module cdec_chunk_decoder
  import cdec_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int EVENTS   = 7,
  parameter int CLUSTERS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_start,
  input  logic [1:0]          mode,
  input  logic [2*BYTE_W-1:0] limit,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_data,
  output logic                in_ready,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*BYTE_W-1:0] out_sample
);
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int LOG2_MAX = MAX_SPE_LOG2;
  localparam int PAD_W    = WORD_W + LOG2_MAX;

  logic              word_valid, word_is_ts, word_cluster_end, word_chunk_end, word_take;
  logic [WORD_W-1:0] word_data;

  seq_state_t          state;
  logic                first;
  logic [WORD_W-1:0]   base_ts, last_smp, evt, unpacked;
  logic                evt_end;
  logic [LOG2_MAX-1:0] sub, sub_last;
  logic [PAD_W-1:0]    pad_cnt, pad_new;
  logic                beyond;
  logic [1:0]          spe_lg;
  logic                slot_free;

  assign spe_lg    = spe_log2(mode);
  assign sub_last  = LOG2_MAX'((1 << spe_lg) - 1);
  assign slot_free = !out_valid || out_ready;
  assign word_take = word_valid && (state == ST_TS || state == ST_EVT || state == ST_SKIP);

  cdec_word_collect #(.BYTE_W(BYTE_W), .EVENTS(EVENTS), .CLUSTERS(CLUSTERS)) u_collect (
    .clk(clk), .rst(rst), .restart(cap_start),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .word_valid(word_valid), .word_data(word_data), .word_is_ts(word_is_ts),
    .word_cluster_end(word_cluster_end), .word_chunk_end(word_chunk_end),
    .word_take(word_take)
  );

  cdec_gap_calc #(.TS_W(WORD_W), .EVENTS(EVENTS), .LOG2_MAX(LOG2_MAX)) u_gap (
    .ts(word_data), .base_ts(base_ts), .limit(limit), .first(first),
    .spe_lg(spe_lg), .pad(pad_new), .beyond(beyond)
  );

  cdec_unpack #(.CH_W(WORD_W), .LOG2_MAX(LOG2_MAX)) u_unpack (
    .word(evt), .sub(sub), .spe_lg(spe_lg), .sample(unpacked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_TS;
      first      <= 1'b1;
      base_ts    <= '0;
      last_smp   <= '0;
      evt        <= '0;
      evt_end    <= 1'b0;
      sub        <= '0;
      pad_cnt    <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else if (cap_start) begin
      state    <= ST_TS;
      first    <= 1'b1;
      last_smp <= '0;
      pad_cnt  <= '0;
      sub      <= '0;
      if (out_valid && out_ready) out_valid <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        ST_TS: if (word_valid) begin
          if (beyond) begin
            state <= ST_SKIP;
          end else begin
            base_ts <= word_data;
            first   <= 1'b0;
            pad_cnt <= pad_new;
            state   <= (pad_new != '0) ? ST_PAD : ST_EVT;
          end
        end
        ST_PAD: if (slot_free) begin
          out_valid  <= 1'b1;
          out_sample <= last_smp;
          pad_cnt    <= pad_cnt - 1'b1;
          if (pad_cnt == PAD_W'(1)) state <= ST_EVT;
        end
        ST_EVT: if (word_valid) begin
          evt     <= word_data;
          evt_end <= word_cluster_end;
          sub     <= '0;
          state   <= ST_SUB;
        end
        ST_SUB: if (slot_free) begin
          out_valid  <= 1'b1;
          out_sample <= unpacked;
          last_smp   <= unpacked;
          if (sub == sub_last) state <= evt_end ? ST_TS : ST_EVT;
          else                 sub   <= sub + 1'b1;
        end
        ST_SKIP: if (word_valid && word_chunk_end) state <= ST_TS;
        default: state <= ST_TS;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_sample)); // R8
  AST_TS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    word_take && word_is_ts |-> (state == ST_TS || state == ST_SKIP)); // R1
  AST_PAD_LIVE: assert property (@(posedge clk) disable iff (rst)
    state == ST_PAD |-> pad_cnt != '0); // R5
  AST_LANE_TWO: assert property (@(posedge clk) disable iff (rst)
    out_valid && mode == 2'b01 |-> out_sample[WORD_W-1:WORD_W/2] == '0); // R3
  AST_LANE_FOUR: assert property (@(posedge clk) disable iff (rst)
    out_valid && mode == 2'b10 |-> out_sample[WORD_W-1:WORD_W/4] == '0); // R4
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
    state == ST_SKIP && !out_valid |=> !out_valid); // R7
  AST_START_REALIGN: assert property (@(posedge clk) disable iff (rst)
    cap_start |=> state == ST_TS); // R6

endmodule

// File: tb/sim_cdec_chunk_decoder.sv
`timescale 1ns/1ps
module sim_cdec_chunk_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] limit = 16'h0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_sample;

  always #2 clk = ~clk;

  cdec_chunk_decoder u0 (
    .clk(clk), .rst(rst), .cap_start(cap_start), .mode(mode), .limit(limit),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  bit    rx_en = 1'b0;
  int    cyc = 0;
  int    ready_pct = 100;
  int    valid_pct = 100;

  logic [7:0]  bq[$];
  logic [15:0] exp_q[$];
  string       tag_q[$];

  logic [15:0] m_base, m_last, m_gen_ts;
  bit          m_first, gen_first;

  task automatic check(input string req, input bit ok, input logic [31:0] act,
                       input logic [31:0] expv, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic logic [15:0] ref_unpack(input logic [15:0] w, input int s, input int k);
    logic [15:0] r = '0;
    for (int l = 0; l < 16 / s; l++) r[l] = w[l * s + k];
    return r;
  endfunction

  task automatic push_word(input logic [15:0] w);
    bq.push_back(w[7:0]);
    bq.push_back(w[15:8]);
  endtask

  // Build one chunk of bytes and the samples the requirements predict for it.
  task automatic gen_chunk(input int md, input int kind, input logic [15:0] lim,
                           input string rtag);
    int s;
    bit skipping = 1'b0;
    s = (md == 1) ? 2 : (md == 2) ? 4 : 1;
    for (int c = 0; c < 64; c++) begin
      logic [15:0] ts, diff;
      int extra = 0;
      string tnow;
      if (kind == 1) extra = ($urandom % 3 == 0) ? int'($urandom % 10) : 0;
      if (kind == 1 && c == 5) extra = 1;   // gap of one event: smallest pad
      if (kind == 2) extra = ($urandom % 16 == 0) ? 100 + int'($urandom % 200) : 0;
      if (gen_first) begin ts = m_gen_ts; gen_first = 1'b0; end
      else ts = m_gen_ts + 16'(7 + extra);
      m_gen_ts = ts;
      push_word(ts);
      if (!skipping && lim != 0 && ts > lim) skipping = 1'b1;
      if (skipping) begin
        for (int e = 0; e < 7; e++) push_word(16'($urandom));
        continue;
      end
      diff = m_first ? 16'd1 : ts - m_base;
      if (diff > 16'd7)
        for (int i = 0; i < (int'(diff) - 7) * s; i++) begin
          exp_q.push_back(m_last); tag_q.push_back("R5");
        end
      tnow = m_first ? "R6" : rtag;
      m_base = ts;
      m_first = 1'b0;
      for (int e = 0; e < 7; e++) begin
        logic [15:0] w;
        w = 16'($urandom);
        push_word(w);
        for (int k = 0; k < s; k++) begin
          logic [15:0] smp;
          smp = ref_unpack(w, s, k);
          exp_q.push_back(smp); tag_q.push_back(tnow);
          m_last = smp;
        end
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit sent = 1'b0;
    while (!sent) begin
      @(negedge clk);
      if (int'($urandom % 100) < valid_pct) begin
        in_valid = 1'b1;
        in_data  = b;
        if (in_ready) sent = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic send_and_drain();
    while (bq.size() > 0) send_byte(bq.pop_front());
    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic start_capture(input logic [1:0] md, input logic [15:0] ts0);
    @(negedge clk);
    cap_start = 1'b1;
    mode      = md;
    m_first   = 1'b1;
    gen_first = 1'b1;
    m_last    = '0;
    m_gen_ts  = ts0;
    @(negedge clk);
    cap_start = 1'b0;
  endtask

  // Output side: random ready, sample comparison, stall stability.
  initial begin
    bit          hold_chk = 1'b0;
    logic [15:0] held = '0;
    forever begin
      @(negedge clk);
      if (rx_en) begin
        out_ready = (int'($urandom % 100) < ready_pct);
        if (hold_chk)
          check("R8", out_valid && out_sample == held, {15'd0, out_valid, out_sample},
                {16'd1, held}, "stalled sample changed");
        hold_chk = out_valid && !out_ready;
        held     = out_sample;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check("R7", 1'b0, {16'd0, out_sample}, 32'hFFFFFFFF, "sample with none expected");
          end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, out_sample == e, {16'd0, out_sample}, {16'd0, e}, "sample value");
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R8 watchdog: actual=%0d cycles expected=completion", cyc);
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    repeat (5) @(negedge clk);
    check("R9", out_valid == 1'b0, {31'd0, out_valid}, 0, "out_valid in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R9", out_valid == 1'b0, {31'd0, out_valid}, 0, "out_valid after reset");
    check("R9", in_ready == 1'b1, {31'd0, in_ready}, 1, "in_ready after reset");
    rx_en = 1'b1;

    // R1 / R2: one sample per event, two chunks in a row, no gaps.
    start_capture(2'b00, 16'h0123);
    gen_chunk(0, 0, 16'h0, "R1");
    gen_chunk(0, 0, 16'h0, "R2");
    send_and_drain();

    // R2 / R5: small random gaps under both-side stalls.
    ready_pct = 60; valid_pct = 70;
    start_capture(2'b00, 16'h4000);
    gen_chunk(0, 1, 16'h0, "R2");
    send_and_drain();

    // R3: two samples per event.
    ready_pct = 50; valid_pct = 80;
    start_capture(2'b01, 16'h2222);
    gen_chunk(1, 1, 16'h0, "R3");
    send_and_drain();

    // R4: four samples per event with occasional long idle gaps.
    ready_pct = 70; valid_pct = 90;
    start_capture(2'b10, 16'h0800);
    gen_chunk(2, 2, 16'h0, "R4");
    send_and_drain();

    // R2: mode 11 behaves as one sample per event.
    ready_pct = 100; valid_pct = 100;
    start_capture(2'b11, 16'h7000);
    gen_chunk(3, 1, 16'h0, "R2");
    send_and_drain();

    // R5: timestamp wrap across two chunks.
    ready_pct = 80;
    start_capture(2'b01, 16'hFF80);
    gen_chunk(1, 1, 16'h0, "R5");
    gen_chunk(1, 1, 16'h0, "R5");
    send_and_drain();

    // R7: limit equals cluster 30's timestamp; 31..63 dropped, next chunk resumes.
    ready_pct = 75; valid_pct = 85;
    start_capture(2'b00, 16'h1000);
    limit = 16'h1000 + 16'(7 * 30);
    gen_chunk(0, 0, limit, "R7");
    send_and_drain();
    check("R7", exp_q.size() == 0, exp_q.size(), 0, "queue after limited chunk");
    limit = 16'h0;
    gen_chunk(0, 0, 16'h0, "R7");
    send_and_drain();

    check("R8", exp_q.size() == 0, exp_q.size(), 0, "samples left undelivered");
    if (!done) begin
      done = 1'b1;
      report();
      $finish;
    end
  end

endmodule